// File: doc/BRIEF.md
# Remote Terminal Interrupt and Transmitter Watchdog

This block turns the internal event strobes of a serial-bus remote terminal into its status and interrupt pins. A valid command word produces a low-going command strobe. The end of receive or transmit memory activity produces an end-of-transfer pulse, filtered by a host-selected mode. The end of mode-code activity produces a pulse that the host cannot mask. A message error sets a latched, active-low error flag, and while that flag is set both interrupt pulses are withheld. All pulses are active low and drive low only while active, so the two interrupt pins can be wire-ORed.

A transmitter-on indication rises when a transmission starts and falls when it stops. A fail-safe watchdog also ends it if the transmission runs too long. The watchdog limit is counted in time units of `TICK_DIV` clock cycles. It is `LIMIT_A` units when the protocol-select input is high and `LIMIT_B` units when it is low. When the watchdog expires, the transmitters are disabled and stay disabled until the next valid command word.

Top module: `term_irq_unit`

## Requirements
- R1: After reset, `cmd_stb_n_o`, `eot_irq_n_o`, `mc_irq_n_o` and `merr_n_o` are high, and `tx_on_o` and `tx_inhibit_o` are low.
- R2: A one-cycle `cmd_valid_i` drives `cmd_stb_n_o` low for exactly `PULSE_CYC` cycles, starting in the cycle after the strobe.
- R3: `eot_sel_i` selects the end-of-transfer source. 2'b00 fires on nothing, 2'b01 fires on `rx_done_i` only, 2'b10 fires on `tx_done_i` only, and 2'b11 fires on either. A selected event drives `eot_irq_n_o` low for `PULSE_CYC` cycles, starting in the next cycle.
- R4: `mc_done_i` drives `mc_irq_n_o` low for `PULSE_CYC` cycles, starting in the next cycle, whatever the value of `eot_sel_i`.
- R5: No interrupt pulse starts from an event that arrives in the same cycle as `msg_err_i`, or while the error flag is set.
- R6: `msg_err_i` drives `merr_n_o` low from the next cycle. It stays low until a cycle with `cmd_valid_i` and without `msg_err_i`, and goes high in the cycle after that one.
- R7: `tx_start_i` raises `tx_on_o` in the next cycle. `tx_stop_i` lowers it in the next cycle, and stop wins over start.
- R8: If `tx_on_o` stays up without a stop, it stays high for exactly LIMIT×`TICK_DIV` cycles. LIMIT is `LIMIT_A` when `proto_a_i` = 1 and `LIMIT_B` when `proto_a_i` = 0. It then falls, and `tx_inhibit_o` rises in the same cycle.
- R9: While `tx_inhibit_o` is high, `tx_start_i` has no effect on `tx_on_o`. A `cmd_valid_i` clears `tx_inhibit_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| proto_a_i | input | 1 | 1 selects the A-variant watchdog limit, 0 the B-variant |
| eot_sel_i | input | 2 | End-of-transfer source select (see R3) |
| cmd_valid_i | input | 1 | Valid command word received (one-cycle strobe) |
| rx_done_i | input | 1 | End of receive memory activity |
| tx_done_i | input | 1 | End of transmit memory activity |
| mc_done_i | input | 1 | End of mode-code memory activity |
| msg_err_i | input | 1 | Message error detected |
| tx_start_i | input | 1 | Transmission begins |
| tx_stop_i | input | 1 | Transmission complete |
| cmd_stb_n_o | output | 1 | Command strobe, active low |
| eot_irq_n_o | output | 1 | End-of-transfer interrupt, active low |
| mc_irq_n_o | output | 1 | End-of-mode-code interrupt, active low |
| merr_n_o | output | 1 | Latched message-error flag, active low |
| tx_on_o | output | 1 | Transmitter on |
| tx_inhibit_o | output | 1 | Transmitters disabled after a watchdog expiry |

## Verification
The bench builds the block with `PULSE_CYC` = 3, `TICK_DIV` = 2, `LIMIT_A` = 6 and `LIMIT_B` = 8. With these values the watchdog expiry falls after 12 cycles for one variant and 16 for the other. Both limits and the recovery through a new command can therefore be reached in a short run, and the prescaler path stays in use. The real-time defaults (12000-cycle units, 600 and 800 units) are left to elaboration only.

// File: rtl/tiu_pkg.sv
package tiu_pkg;

   typedef enum logic [1:0] {
      EOT_NONE = 2'b00,
      EOT_RX   = 2'b01,
      EOT_TX   = 2'b10,
      EOT_BOTH = 2'b11
   } eot_sel_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tiu_pulse_gen.sv
module tiu_pulse_gen #(
   parameter int unsigned WIDTH_CYC  = 3,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   output logic pulse_o
);
   localparam int unsigned CW = $clog2(WIDTH_CYC + 1);

   generate
      if (WIDTH_CYC < 1) begin : g_bad_width
         $error("tiu_pulse_gen: WIDTH_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (trig_i)
         cnt_q <= CW'(WIDTH_CYC);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign active = (cnt_q != '0);

   generate
      if (ACTIVE_LOW) begin : g_low
         assign pulse_o = ~active;
         AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
            trig_i |=> !pulse_o);   // R2
      end else begin : g_high
         assign pulse_o = active;
         AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
            trig_i |=> pulse_o);    // R2
      end
   endgenerate

endmodule

// File: rtl/tiu_failsafe.sv
module tiu_failsafe #(
   parameter int unsigned TICK_DIV = 12000,
   parameter int unsigned LIMIT_A  = 600,
   parameter int unsigned LIMIT_B  = 800
) (
   input  logic clk,
   input  logic rst_n,
   input  logic proto_a_i,
   input  logic cmd_valid_i,
   input  logic start_i,
   input  logic stop_i,
   output logic tx_on_o,
   output logic inhibit_o
);
   localparam int unsigned LMAX = tiu_pkg::max_u(LIMIT_A, LIMIT_B);
   localparam int unsigned UW   = $clog2(LMAX + 1);

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("tiu_failsafe: TICK_DIV must be at least 1");
      end
      if (LIMIT_A < 1 || LIMIT_B < 1) begin : g_bad_limit
         $error("tiu_failsafe: limits must be at least 1");
      end
   endgenerate

   logic          tx_on_q;
   logic          inhibit_q;
   logic [UW-1:0] units_q;
   logic [UW-1:0] limit;
   logic          tick;
   logic          expire;

   assign limit = proto_a_i ? UW'(LIMIT_A) : UW'(LIMIT_B);

   generate
      if (TICK_DIV == 1) begin : g_no_pre
         assign tick = tx_on_q;
      end else begin : g_pre
         localparam int unsigned PW = $clog2(TICK_DIV);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre_q <= '0;
            else if (!tx_on_q || pre_q == PW'(TICK_DIV - 1))
               pre_q <= '0;
            else
               pre_q <= pre_q + 1'b1;
         end
         assign tick = tx_on_q && (pre_q == PW'(TICK_DIV - 1));
      end
   endgenerate

   assign expire = tick && !stop_i && (units_q >= limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_on_q <= 1'b0;
         units_q <= '0;
      end else if (stop_i) begin
         tx_on_q <= 1'b0;
         units_q <= '0;
      end else if (expire) begin
         tx_on_q <= 1'b0;
         units_q <= '0;
      end else if (tick) begin
         units_q <= units_q + 1'b1;
      end else if (!tx_on_q && start_i && (!inhibit_q || cmd_valid_i)) begin
         tx_on_q <= 1'b1;
         units_q <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         inhibit_q <= 1'b0;
      else if (expire)
         inhibit_q <= 1'b1;
      else if (cmd_valid_i)
         inhibit_q <= 1'b0;
   end

   assign tx_on_o   = tx_on_q;
   assign inhibit_o = inhibit_q;

   AST_STOP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> !tx_on_q);                                        // R7
   AST_START_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !stop_i && !tx_on_q && !inhibit_q) |=> tx_on_q);  // R7
   AST_EXPIRE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (inhibit_q && !tx_on_q));                         // R8
   AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (inhibit_q && !cmd_valid_i) |=> !tx_on_q);                   // R9

endmodule

// File: rtl/term_irq_unit.sv
module term_irq_unit #(
   parameter int unsigned PULSE_CYC = 3,
   parameter int unsigned TICK_DIV  = 12000,
   parameter int unsigned LIMIT_A   = 600,
   parameter int unsigned LIMIT_B   = 800
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       proto_a_i,
   input  logic [1:0] eot_sel_i,
   input  logic       cmd_valid_i,
   input  logic       rx_done_i,
   input  logic       tx_done_i,
   input  logic       mc_done_i,
   input  logic       msg_err_i,
   input  logic       tx_start_i,
   input  logic       tx_stop_i,
   output logic       cmd_stb_n_o,
   output logic       eot_irq_n_o,
   output logic       mc_irq_n_o,
   output logic       merr_n_o,
   output logic       tx_on_o,
   output logic       tx_inhibit_o
);
   import tiu_pkg::*;

   eot_sel_e sel;
   logic     err_q;
   logic     err_now;
   logic     eot_trig;
   logic     mc_trig;

   assign sel     = eot_sel_e'(eot_sel_i);
   assign err_now = err_q | msg_err_i;

   always_comb begin
      eot_trig = 1'b0;
      unique case (sel)
         EOT_NONE: eot_trig = 1'b0;
         EOT_RX:   eot_trig = rx_done_i;
         EOT_TX:   eot_trig = tx_done_i;
         EOT_BOTH: eot_trig = rx_done_i | tx_done_i;
         default:  eot_trig = 1'b0;
      endcase
      eot_trig = eot_trig & ~err_now;
   end

   assign mc_trig = mc_done_i & ~err_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err_q <= 1'b0;
      else if (msg_err_i)
         err_q <= 1'b1;
      else if (cmd_valid_i)
         err_q <= 1'b0;
   end

   assign merr_n_o = ~err_q;

   tiu_pulse_gen #(.WIDTH_CYC(PULSE_CYC), .ACTIVE_LOW(1'b1)) u_cmd_pulse (
      .clk(clk), .rst_n(rst_n), .trig_i(cmd_valid_i), .pulse_o(cmd_stb_n_o));

   tiu_pulse_gen #(.WIDTH_CYC(PULSE_CYC), .ACTIVE_LOW(1'b1)) u_eot_pulse (
      .clk(clk), .rst_n(rst_n), .trig_i(eot_trig), .pulse_o(eot_irq_n_o));

   tiu_pulse_gen #(.WIDTH_CYC(PULSE_CYC), .ACTIVE_LOW(1'b1)) u_mc_pulse (
      .clk(clk), .rst_n(rst_n), .trig_i(mc_trig), .pulse_o(mc_irq_n_o));

   tiu_failsafe #(.TICK_DIV(TICK_DIV), .LIMIT_A(LIMIT_A), .LIMIT_B(LIMIT_B)) u_failsafe (
      .clk(clk), .rst_n(rst_n), .proto_a_i(proto_a_i), .cmd_valid_i(cmd_valid_i),
      .start_i(tx_start_i), .stop_i(tx_stop_i),
      .tx_on_o(tx_on_o), .inhibit_o(tx_inhibit_o));

   AST_MERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      msg_err_i |=> !merr_n_o);                                     // R6
   AST_MERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!merr_n_o && !cmd_valid_i) |=> !merr_n_o);                   // R6
   AST_EOT_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
      ((msg_err_i || !merr_n_o) && eot_irq_n_o) |=> eot_irq_n_o);   // R5
   AST_MC_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
      ((msg_err_i || !merr_n_o) && mc_irq_n_o) |=> mc_irq_n_o);     // R5
   AST_MC_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (mc_done_i && !msg_err_i && merr_n_o) |=> !mc_irq_n_o);       // R4

endmodule

// File: tb/sim_term_irq_unit.sv
module sim_term_irq_unit;
   localparam int unsigned PC = 3;
   localparam int unsigned TD = 2;
   localparam int unsigned LA = 6;
   localparam int unsigned LB = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic proto_a = 1'b1;
   logic [1:0] sel = 2'b00;
   logic cmd_v = 1'b0, rx_d = 1'b0, tx_d = 1'b0, mc_d = 1'b0, err = 1'b0;
   logic t_start = 1'b0, t_stop = 1'b0;
   logic cmd_stb_n, eot_n, mc_n, merr_n, tx_on, tx_inh;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   term_irq_unit #(.PULSE_CYC(PC), .TICK_DIV(TD), .LIMIT_A(LA), .LIMIT_B(LB)) u0 (
      .clk(clk), .rst_n(rst_n), .proto_a_i(proto_a), .eot_sel_i(sel),
      .cmd_valid_i(cmd_v), .rx_done_i(rx_d), .tx_done_i(tx_d), .mc_done_i(mc_d),
      .msg_err_i(err), .tx_start_i(t_start), .tx_stop_i(t_stop),
      .cmd_stb_n_o(cmd_stb_n), .eot_irq_n_o(eot_n), .mc_irq_n_o(mc_n),
      .merr_n_o(merr_n), .tx_on_o(tx_on), .tx_inhibit_o(tx_inh));

   // [7:6] sel, [5] rx, [4] tx, [3] mc, [2] err, [1] expect eot low, [0] expect mc low
   localparam int NV = 12;
   localparam logic [7:0] VEC [NV] = '{
      {2'b00, 4'b1000, 2'b00},   // R3 none selected, rx ignored
      {2'b01, 4'b1000, 2'b10},   // R3 rx select
      {2'b01, 4'b0100, 2'b00},   // R3 rx select ignores tx
      {2'b10, 4'b0100, 2'b10},   // R3 tx select
      {2'b10, 4'b1000, 2'b00},   // R3 tx select ignores rx
      {2'b11, 4'b1000, 2'b10},   // R3 either, rx
      {2'b11, 4'b0100, 2'b10},   // R3 either, tx
      {2'b00, 4'b0010, 2'b01},   // R4 mode code with nothing selected
      {2'b11, 4'b1001, 2'b00},   // R5 rx with error same cycle
      {2'b00, 4'b0011, 2'b00},   // R5 mode code with error same cycle
      {2'b11, 4'b1010, 2'b11},   // R3 R4 both at once
      {2'b00, 4'b0000, 2'b00}    // R3 idle
   };

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic clear_inputs();
      cmd_v = 1'b0; rx_d = 1'b0; tx_d = 1'b0; mc_d = 1'b0; err = 1'b0;
      t_start = 1'b0; t_stop = 1'b0;
   endtask

   task automatic run_timeout(input logic pa, input int unsigned lim, input string req);
      proto_a = pa;
      t_start = 1'b1;
      step();
      t_start = 1'b0;
      repeat (lim * TD - 1) @(posedge clk);
      @(negedge clk);
      check({req, " tx_on high at last cycle"}, tx_on, 1'b1);
      check({req, " inhibit low before expiry"}, tx_inh, 1'b0);
      @(negedge clk);
      check({req, " tx_on falls at limit"}, tx_on, 1'b0);
      check({req, " inhibit rises at limit"}, tx_inh, 1'b1);
      #1;
      t_start = 1'b1;                 // R9 start while inhibited
      step();
      t_start = 1'b0;
      @(negedge clk);
      check("R9 start ignored while inhibited", tx_on, 1'b0);
      check("R9 inhibit held", tx_inh, 1'b1);
      #1;
      cmd_v = 1'b1;
      step();
      cmd_v = 1'b0;
      @(negedge clk);
      check("R9 command clears inhibit", tx_inh, 1'b0);
      repeat (PC + 1) step();
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 cmd_stb_n reset", cmd_stb_n, 1'b1);
      check("R1 eot_n reset", eot_n, 1'b1);
      check("R1 mc_n reset", mc_n, 1'b1);
      check("R1 merr_n reset", merr_n, 1'b1);
      check("R1 tx_on reset", tx_on, 1'b0);
      check("R1 inhibit reset", tx_inh, 1'b0);
      rst_n = 1'b1;
      step();

      // table walk
      for (int i = 0; i < NV; i++) begin
         sel  = VEC[i][7:6];
         rx_d = VEC[i][5]; tx_d = VEC[i][4]; mc_d = VEC[i][3]; err = VEC[i][2];
         step();
         clear_inputs();
         @(negedge clk);
         check($sformatf("R3 R5 eot vector %0d", i), eot_n, ~VEC[i][1]);
         check($sformatf("R4 R5 mc vector %0d", i), mc_n, ~VEC[i][0]);
         #1;
         repeat (PC + 1) step();
         if (VEC[i][2]) begin
            cmd_v = 1'b1;
            step();
            cmd_v = 1'b0;
            repeat (PC + 1) step();
         end
      end

      // R2 command strobe width
      cmd_v = 1'b1;
      step();
      cmd_v = 1'b0;
      for (int k = 0; k < int'(PC); k++) begin
         @(negedge clk);
         check("R2 cmd strobe low", cmd_stb_n, 1'b0);
      end
      @(negedge clk);
      check("R2 cmd strobe ends", cmd_stb_n, 1'b1);
      #1;
      step();

      // R6 error latch and R5 suppression while latched
      err = 1'b1;
      step();
      err = 1'b0;
      @(negedge clk);
      check("R6 merr set", merr_n, 1'b0);
      #1;
      sel = 2'b11; rx_d = 1'b1; mc_d = 1'b1;
      step();
      rx_d = 1'b0; mc_d = 1'b0;
      @(negedge clk);
      check("R5 eot held off by flag", eot_n, 1'b1);
      check("R5 mc held off by flag", mc_n, 1'b1);
      check("R6 merr persists", merr_n, 1'b0);
      #1;
      cmd_v = 1'b1; err = 1'b1;        // error wins over clear
      step();
      cmd_v = 1'b0; err = 1'b0;
      @(negedge clk);
      check("R6 error with command keeps flag", merr_n, 1'b0);
      #1;
      cmd_v = 1'b1;
      step();
      cmd_v = 1'b0;
      @(negedge clk);
      check("R6 command clears flag", merr_n, 1'b1);
      #1;
      repeat (PC + 1) step();

      // R7 start and stop
      t_start = 1'b1;
      step();
      t_start = 1'b0;
      @(negedge clk);
      check("R7 start raises tx_on", tx_on, 1'b1);
      #1;
      t_stop = 1'b1; t_start = 1'b1;
      step();
      t_stop = 1'b0; t_start = 1'b0;
      @(negedge clk);
      check("R7 stop lowers tx_on", tx_on, 1'b0);
      check("R7 no inhibit after stop", tx_inh, 1'b0);
      #1;
      step();

      // R8 both protocol limits
      run_timeout(1'b1, LA, "R8 A");
      run_timeout(1'b0, LB, "R8 B");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule